// File: doc/BRIEF.md
# PCI configuration address translator

This block sits between a host register bus and a PCI configuration port. The register space holds two windows of 4 KiB each. The lower window holds a 32-bit configuration index register. An access to the upper window is forwarded at once to the configuration port. It uses an address derived from the index register together with the low bits of the access offset.

Before forwarding, the block rewrites the index. An index whose top bit is set passes through, with its two lowest bits merged from the offset. An index with the top bit clear and bit 0 set is taken as a type-1 address. Its three lowest bits are replaced by the offset. Any other index is read as a one-hot device select. The lowest set bit in bits 31:11 gives the device slot. The block then builds a standard bus/device/function/register address with the enable bit set.

Byte, halfword and word accesses are supported, with little-endian lane placement. The translation is combinational, so every data-window access uses the index value as it stands in that cycle.

Top module: `cfg_addr_xlate`

## Requirements
- R1: While reset is asserted, and after it, the index register reads as zero. cfg_valid stays low whenever no upper-window request is present.
- R2: A write to the lower window (req_addr bit 12 = 0) loads all 32 bits of req_wdata into the index register at the clock edge, whatever req_size says. A read of the lower window returns the full index register.
- R3: When index bit 31 is 1, cfg_addr equals the index with bits 1:0 ORed with req_addr[1:0].
- R4: When index bit 31 is 0 and bit 0 is 1, cfg_addr is {index[31:3], req_addr[2:0]}.
- R5: Otherwise, the slot is the position, counted from bit 11, of the lowest set bit in index[31:11]. cfg_addr is then formed as follows:
  - bit 31 = 1;
  - bits 30:16 = 0;
  - bits 15:11 = slot;
  - bits 10:8 = index[10:8];
  - bits 7:3 = index[7:3];
  - bits 2:0 = req_addr[2:0].
- R6: In the case of R5, when index[31:11] is all zero, the slot field is 5'h1F.
- R7: cfg_valid is 1 exactly when req_valid is 1 and req_addr bit 12 is 1. cfg_write then equals req_write. A lower-window access never raises cfg_valid.
- R8: The byte lane start is set by req_size:
  - code 0 (1 byte): lane start is req_addr[1:0];
  - code 1 (2 bytes): lane start is {req_addr[1],0};
  - codes 2 and 3 (4 bytes): lane start is 0.
  cfg_be has one bit per byte of the access, starting at that lane.
- R9: On a data-window write, cfg_wdata carries req_wdata shifted up by 8 × lane start. Bit 0 of req_wdata goes to bit 0 of the first enabled byte.
- R10: On a data-window read, rsp_rdata is cfg_rdata shifted down by 8 × lane start. Bits above the access width are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register bus access this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 13 | Byte offset; bit 12 selects the data window |
| req_size | input | 2 | 0 = byte, 1 = halfword, 2/3 = word |
| req_wdata | input | 32 | Write data, LSB-justified |
| rsp_rdata | output | 32 | Read data, LSB-justified |
| cfg_valid | output | 1 | Configuration access strobe |
| cfg_write | output | 1 | Configuration access direction |
| cfg_addr | output | 32 | Translated configuration address |
| cfg_be | output | 4 | Byte enables |
| cfg_wdata | output | 32 | Lane-aligned write data |
| cfg_rdata | input | 32 | Configuration read data from the port |

## Verification
Loading the index register and translating a data-window access meet when a data access lands in the cycle right after an index write. That access must already see the new index. The bench provokes this by issuing every index write back-to-back with the following data access, across one-hot, empty, type-1 and enable-bit indices. It judges each forwarded address against a bench model that holds only the index value last written.

// File: rtl/cfg_addr_xlate.sv
module cfg_addr_xlate #(
  parameter int WIN_BITS = 12,
  parameter int SLOT_LSB = 11,
  parameter int FUNC_LSB = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [WIN_BITS:0] req_addr,
  input  logic [1:0]  req_size,
  input  logic [31:0] req_wdata,
  output logic [31:0] rsp_rdata,
  output logic        cfg_valid,
  output logic        cfg_write,
  output logic [31:0] cfg_addr,
  output logic [3:0]  cfg_be,
  output logic [31:0] cfg_wdata,
  input  logic [31:0] cfg_rdata
);
  localparam int SEL_W = 32 - SLOT_LSB;

  logic [31:0] index_q;
  logic [4:0]  slot;
  logic [1:0]  lane;
  logic [31:0] rd_shift;
  logic [31:0] rd_mask;

  wire       data_win = req_addr[WIN_BITS];
  wire [2:0] off      = req_addr[2:0];

  always_ff @(posedge clk) begin
    if (!rst_n)
      index_q <= '0;
    else if (req_valid && req_write && !data_win)
      index_q <= req_wdata;
  end

  always_comb begin
    slot = 5'h1F;
    for (int i = SEL_W - 1; i >= 0; i--)
      if (index_q[SLOT_LSB + i]) slot = 5'(i);
  end

  always_comb begin
    if (index_q[31]) begin
      cfg_addr = index_q | {30'b0, off[1:0]};
    end else if (index_q[0]) begin
      cfg_addr = {index_q[31:3], off};
    end else begin
      cfg_addr = '0;
      cfg_addr[31] = 1'b1;
      cfg_addr[SLOT_LSB +: 5] = slot;
      cfg_addr[FUNC_LSB +: 3] = index_q[FUNC_LSB +: 3];
      cfg_addr[7:3] = index_q[7:3];
      cfg_addr[2:0] = off;
    end
  end

  always_comb begin
    case (req_size)
      2'd0: begin lane = off[1:0];       cfg_be = 4'b0001 << off[1:0];        rd_mask = 32'h0000_00FF; end
      2'd1: begin lane = {off[1], 1'b0}; cfg_be = 4'b0011 << {off[1], 1'b0}; rd_mask = 32'h0000_FFFF; end
      default: begin lane = 2'd0;        cfg_be = 4'hF;                       rd_mask = 32'hFFFF_FFFF; end
    endcase
  end

  assign cfg_valid = req_valid && data_win;
  assign cfg_write = req_write;
  assign cfg_wdata = req_wdata << {lane, 3'b000};
  assign rd_shift  = cfg_rdata >> {lane, 3'b000};
  assign rsp_rdata = data_win ? (rd_shift & rd_mask) : index_q;

  a_r2_index_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && !data_win) |=> (index_q == $past(req_wdata)));

  a_r7_no_fwd_index: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_addr[WIN_BITS]) |-> !cfg_valid);

  a_r3_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && index_q[31]) |-> (cfg_addr[31:2] == index_q[31:2]));

  a_r5_enable_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && !index_q[0]) |-> cfg_addr[31]);

  a_r6_no_device: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && index_q[31:11] == '0 && !index_q[0]) |-> (cfg_addr[15:11] == 5'h1F));

  a_r8_be_width: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |-> ($countones(cfg_be) == 1 || $countones(cfg_be) == 2 || $countones(cfg_be) == 4));
endmodule

// File: tb/cfg_addr_xlate_tb_top.sv
module cfg_addr_xlate_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [12:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] rsp_rdata;
  logic        cfg_valid;
  logic        cfg_write;
  logic [31:0] cfg_addr;
  logic [3:0]  cfg_be;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata = '0;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;
  logic [31:0] model_idx = '0;

  always #10 clk = ~clk;

  cfg_addr_xlate dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_rdata(rsp_rdata), .cfg_valid(cfg_valid), .cfg_write(cfg_write),
    .cfg_addr(cfg_addr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_addr(logic [31:0] idx, logic [2:0] off);
    logic [31:0] r;
    int s;
    if (idx[31]) return {idx[31:2], idx[1:0] | off[1:0]};
    if (idx[0]) return {idx[31:3], off};
    s = 31;
    for (int i = 11; i < 32; i++) if (idx[i]) begin s = i - 11; break; end
    r = 32'h8000_0000 | (32'(s) << 11) | (32'(idx[10:8]) << 8) | {24'b0, idx[7:3], off};
    return r;
  endfunction

  function automatic int exp_lane(logic [1:0] sz, logic [2:0] off);
    if (sz == 2'd0) return int'(off[1:0]);
    if (sz == 2'd1) return off[1] ? 2 : 0;
    return 0;
  endfunction

  function automatic int exp_bytes(logic [1:0] sz);
    return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
  endfunction

  function automatic logic [3:0] exp_be(logic [1:0] sz, logic [2:0] off);
    logic [3:0] b;
    b = 4'((1 << exp_bytes(sz)) - 1);
    return b << exp_lane(sz, off);
  endfunction

  task automatic set_index(logic [31:0] v);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = {1'b0, 12'($urandom)};
    req_size = 2'($urandom); req_wdata = v;
    model_idx = v;
  endtask

  task automatic read_index();
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = {1'b0, 12'($urandom)}; req_size = 2'd2;
    #2;
    chk("R2 index readback", rsp_rdata, model_idx);
    chk("R7 index window not forwarded", {31'b0, cfg_valid}, 32'd0);
  endtask

  task automatic data_access(bit wr, logic [11:0] off, logic [1:0] sz, logic [31:0] wd, logic [31:0] rd);
    logic [31:0] mask;
    int ln;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = {1'b1, off}; req_size = sz;
    req_wdata = wd; cfg_rdata = rd;
    #2;
    ln = exp_lane(sz, off[2:0]);
    mask = (exp_bytes(sz) == 4) ? 32'hFFFF_FFFF : ((32'd1 << (8 * exp_bytes(sz))) - 1);
    chk("R7 cfg_valid", {31'b0, cfg_valid}, 32'd1);
    chk("R7 cfg_write", {31'b0, cfg_write}, {31'b0, wr});
    chk(model_idx[31] ? "R3 addr" : model_idx[0] ? "R4 addr" :
        (model_idx[31:11] == 0) ? "R6 addr" : "R5 addr",
        cfg_addr, exp_addr(model_idx, off[2:0]));
    chk("R8 byte enables", {28'b0, cfg_be}, {28'b0, exp_be(sz, off[2:0])});
    if (wr)
      chk("R9 write lanes", cfg_wdata & (mask << (8 * ln)), (wd & mask) << (8 * ln));
    else
      chk("R10 read align", rsp_rdata, (rd >> (8 * ln)) & mask);
  endtask

  initial begin
    void'($urandom(32'd7391));
    repeat (3) @(negedge clk);
    #2;
    chk("R1 reset idle", {31'b0, cfg_valid}, 32'd0);
    chk("R1 reset index", rsp_rdata, 32'd0);
    @(negedge clk); rst_n = 1;
    #2;
    chk("R1 idle after reset", {31'b0, cfg_valid}, 32'd0);
    read_index();

    set_index(32'h8000_1234);
    data_access(0, 12'h003, 2'd0, 0, 32'hA1B2C3D4);
    set_index(32'h0012_3459);
    data_access(1, 12'h006, 2'd1, 32'h0000BEEF, 0);
    set_index(32'h0000_0800 | 32'h0000_05A8);
    data_access(0, 12'h002, 2'd1, 0, 32'h11223344);
    set_index(32'h0004_0000 | 32'h0100_0000 | 32'h0000_0310);
    data_access(1, 12'h001, 2'd2, 32'hCAFEF00D, 0);
    set_index(32'h4000_0000);
    data_access(0, 12'h007, 2'd0, 0, 32'h55667788);
    set_index(32'h0000_07F8);
    data_access(0, 12'h000, 2'd3, 0, 32'h99AABBCC);
    read_index();
    set_index(32'h0000_0003);
    data_access(1, 12'h005, 2'd0, 32'h000000AB, 0);

    for (int n = 0; n < 300; n++) begin
      logic [31:0] v;
      case ($urandom % 4)
        0: v = $urandom | 32'h8000_0000;
        1: v = ($urandom & 32'h7FFF_FFFF) | 32'h1;
        2: v = (32'h1 << (11 + ($urandom % 20))) | ($urandom & 32'h0000_07FE);
        default: v = $urandom & 32'h0000_07FE;
      endcase
      set_index(v);
      for (int k = 0; k < 2; k++)
        data_access(1'($urandom), 12'($urandom), 2'($urandom), $urandom, $urandom);
      if (n % 25 == 0) read_index();
    end

    @(negedge clk); req_valid = 0;
    #2;
    chk("R1 idle no request", {31'b0, cfg_valid}, 32'd0);
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1;
      compared++; mismatched++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule